// File: doc/BRIEF.md
# Error Interrupt Status Collector

This block gathers six single-cycle error event pulses from link and bus logic. Each pulse sets a sticky bit in a raw status word. The raw word is latched whether or not that source is enabled. A separate enable word masks the raw word to give an enabled status word. The OR of the enabled status drives one error interrupt line. The OR of the enabled fatal-class bits drives a separate fatal line.

The event bit order is:

| Bit | Event |
|-----|-------|
| 0 | system error |
| 1 | fatal |
| 2 | non-fatal |
| 3 | correctable |
| 4 | bus tag-lookup fatal |
| 5 | ECRC |

Bits 1 and 4 form the fatal class.

Software reaches the block through a small request channel. The channel carries valid and ready, a write flag, a byte address and write data. The block never applies back-pressure: `req_ready_o` is held high, so every cycle with `req_valid_i` high is one complete access. A read produces exactly one response, with `rsp_valid_o` high for a single cycle. The response cannot be stalled, so the requester must take it in that cycle. Writes produce no response. Software enables sources through an enable-set register and disables them through an enable-clear register. It acknowledges events by writing ones to either status register.

Top module: `err_irq_collector`

## Requirements
- R1: After reset, both outputs are low and all four registers read as zero.
- R2: A pulse on `err_evt_i[k]` sets raw status bit k on the next clock edge, whether or not bit k is enabled, and the bit stays set until it is cleared.
- R3: A read of the enabled status (offset 0x04) returns raw status AND enable.
- R4: A write to enable-set (offset 0x08) sets every enable bit whose data bit is one. Data bits that are zero leave their enable bits unchanged.
- R5: A write to enable-clear (offset 0x0C) clears every enable bit whose data bit is one. A read of either offset 0x08 or offset 0x0C returns the enable word.
- R6: A write to raw status (offset 0x00) or to enabled status (offset 0x04) clears each raw bit whose data bit is one. Zero data bits leave their raw bits unchanged.
- R7: When an event pulse and a clearing write hit the same bit in one cycle, the bit stays set.
- R8: `err_irq_o` is high exactly when at least one bit is both raw-set and enabled.
- R9: `err_fatal_o` is high exactly when bit 1 or bit 4 is both raw-set and enabled.
- R10: Read bits 31 to 6 are zero and write data bits 31 to 6 are ignored. Offsets at or above 0x10 read as zero, and writes to them have no effect.
- R11: `req_ready_o` is always high. A read accepted in cycle n gives `rsp_valid_o` high for exactly cycle n+1, carrying the register value from cycle n. Writes give no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| err_evt_i | input | 6 | single-cycle error event pulses, one per source |
| req_valid_i | input | 1 | access request valid |
| req_ready_o | output | 1 | access request ready (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | byte address of the access |
| req_wdata_i | input | 32 | write data |
| rsp_valid_o | output | 1 | read response valid, one cycle |
| rsp_data_o | output | 32 | read response data |
| err_irq_o | output | 1 | error interrupt |
| err_fatal_o | output | 1 | fatal error indication |

## Verification
Two functions can fall in the same cycle: a new event pulse on a source, and a write-one-to-clear from software that acknowledges that same source. The bench provokes this by driving the pulse and a status write with a one in the same bit position during a single clock cycle. It judges the result by reading the status back afterwards and by checking that the interrupt line stays high. The bench also overlaps an enable-set write with a fresh pulse, and checks that the enabled status and the interrupt both reflect that pulse on the following cycle.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;

  typedef enum logic [1:0] {
    SEL_RAW    = 2'd0,
    SEL_MASKED = 2'd1,
    SEL_EN_SET = 2'd2,
    SEL_EN_CLR = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
  } acc_dec_t;

endpackage

// File: rtl/err_acc_decode.sv
module err_acc_decode
  import err_irq_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]    BASE_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_dec_t          dec_o
);
  // Four 32-bit words: offset bits [3:2] choose the register.
  localparam int unsigned WIN_LSB = 4;

  logic unused_low;
  assign unused_low = ^addr_i[1:0];

  always_comb begin
    dec_o.hit = (addr_i[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
    dec_o.sel = reg_sel_e'(addr_i[WIN_LSB-1:2]);
  end
endmodule

// File: rtl/err_status_latch.sv
module err_status_latch #(
  parameter int unsigned NUM_ERR = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ERR-1:0] evt_i,
  input  logic [NUM_ERR-1:0] clr_i,
  output logic [NUM_ERR-1:0] raw_o
);
  for (genvar k = 0; k < NUM_ERR; k++) begin : g_bit
    logic bit_q;
    // A new event wins over a simultaneous acknowledge.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (evt_i[k]) bit_q <= 1'b1;
      else if (clr_i[k]) bit_q <= 1'b0;
    end
    assign raw_o[k] = bit_q;
  end
endmodule

// File: rtl/err_enable_pair.sv
module err_enable_pair #(
  parameter int unsigned NUM_ERR = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ERR-1:0] set_i,
  input  logic [NUM_ERR-1:0] clr_i,
  output logic [NUM_ERR-1:0] en_o
);
  logic [NUM_ERR-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q | set_i) & ~clr_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/err_read_port.sv
module err_read_port
  import err_irq_pkg::*;
#(
  parameter int unsigned NUM_ERR = 6,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_fire_i,
  input  acc_dec_t           dec_i,
  input  logic [NUM_ERR-1:0] raw_i,
  input  logic [NUM_ERR-1:0] en_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_data_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_ERR;

  logic [NUM_ERR-1:0] sel_val;
  logic               valid_q;
  logic [DATA_W-1:0]  data_q;

  always_comb begin
    unique case (dec_i.sel)
      SEL_RAW:    sel_val = raw_i;
      SEL_MASKED: sel_val = raw_i & en_i;
      default:    sel_val = en_i;
    endcase
    if (!dec_i.hit) sel_val = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_fire_i;
      if (rd_fire_i) data_q <= {{PAD_W{1'b0}}, sel_val};
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_data_o  = data_q;
endmodule

// File: rtl/err_irq_collector.sv
module err_irq_collector
  import err_irq_pkg::*;
#(
  parameter int unsigned       NUM_ERR   = 6,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter logic [NUM_ERR-1:0] FATAL_SEL = NUM_ERR'(6'b01_0010)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ERR-1:0] err_evt_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_data_o,
  output logic               err_irq_o,
  output logic               err_fatal_o
);
  acc_dec_t           dec;
  logic               wr_fire, rd_fire;
  logic [NUM_ERR-1:0] wbits;
  logic [NUM_ERR-1:0] stat_clr, en_set, en_clr;
  logic [NUM_ERR-1:0] raw_q, en_q, masked;
  logic               unused_wdata;

  assign unused_wdata = ^req_wdata_i[DATA_W-1:NUM_ERR];
  assign req_ready_o  = 1'b1;
  assign wr_fire      = req_valid_i &  req_write_i & dec.hit;
  assign rd_fire      = req_valid_i & ~req_write_i;
  assign wbits        = req_wdata_i[NUM_ERR-1:0];

  err_acc_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i (req_addr_i),
    .dec_o  (dec)
  );

  always_comb begin
    stat_clr = '0;
    en_set   = '0;
    en_clr   = '0;
    if (wr_fire) begin
      unique case (dec.sel)
        SEL_RAW, SEL_MASKED: stat_clr = wbits;
        SEL_EN_SET:          en_set   = wbits;
        default:             en_clr   = wbits;
      endcase
    end
  end

  err_status_latch #(.NUM_ERR(NUM_ERR)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (err_evt_i),
    .clr_i  (stat_clr),
    .raw_o  (raw_q)
  );

  err_enable_pair #(.NUM_ERR(NUM_ERR)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (en_set),
    .clr_i  (en_clr),
    .en_o   (en_q)
  );

  err_read_port #(.NUM_ERR(NUM_ERR), .DATA_W(DATA_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_fire_i   (rd_fire),
    .dec_i       (dec),
    .raw_i       (raw_q),
    .en_i        (en_q),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o)
  );

  assign masked      = raw_q & en_q;
  assign err_irq_o   = |masked;
  assign err_fatal_o = |(masked & FATAL_SEL);
endmodule

// File: rtl/err_irq_collector_chk.sv
module err_irq_collector_chk #(
  parameter int unsigned NUM_ERR = 6,
  parameter int unsigned DATA_W  = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_ERR-1:0] err_evt_i,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               req_write_i,
  input logic               rsp_valid_o,
  input logic [DATA_W-1:0]  rsp_data_o,
  input logic               err_irq_o,
  input logic               err_fatal_o,
  input logic [NUM_ERR-1:0] raw_q,
  input logic [NUM_ERR-1:0] en_q
);
  assert_evt_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_evt_i != '0) |=> ((raw_q & $past(err_evt_i)) == $past(err_evt_i)));

  assert_raw_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_write_i) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

  assert_en_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_write_i) |=> $stable(en_q));

  assert_irq_needs_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> (en_q != '0 && raw_q != '0));

  assert_fatal_in_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_fatal_o |-> err_irq_o);

  assert_rsp_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);

  assert_rsp_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> !rsp_valid_o);

  assert_ready_high_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o);

  assert_pad_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_data_o[DATA_W-1:NUM_ERR] == '0));
endmodule

bind err_irq_collector err_irq_collector_chk #(.NUM_ERR(NUM_ERR), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .err_evt_i   (err_evt_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_write_i (req_write_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_data_o  (rsp_data_o),
  .err_irq_o   (err_irq_o),
  .err_fatal_o (err_fatal_o),
  .raw_q       (raw_q),
  .en_q        (en_q)
);

// File: tb/test_err_irq_collector.sv
module test_err_irq_collector;
  localparam int unsigned NV = 11;
  localparam logic [7:0] A_RAW = 8'h00, A_MSK = 8'h04, A_SET = 8'h08, A_CLR = 8'h0C;

  typedef struct packed {
    logic [5:0] evt;
    logic       wr;
    logic [7:0] waddr;
    logic [5:0] wdata;
    logic [7:0] raddr;
    logic [5:0] erd;
    logic       eirq;
    logic       efat;
  } vec_t;

  // Each entry: one action cycle, then a read of raddr; hand-derived expectations.
  localparam vec_t VECS [NV] = '{
    '{6'h01, 1'b0, A_RAW, 6'h00, A_RAW, 6'h01, 1'b0, 1'b0}, // R2 latch while disabled
    '{6'h00, 1'b1, A_SET, 6'h3F, A_MSK, 6'h01, 1'b1, 1'b0}, // R4 R3 R8
    '{6'h10, 1'b0, A_RAW, 6'h00, A_MSK, 6'h11, 1'b1, 1'b1}, // R9 bus tag-lookup fatal
    '{6'h00, 1'b1, A_CLR, 6'h11, A_SET, 6'h2E, 1'b0, 1'b0}, // R5
    '{6'h02, 1'b0, A_RAW, 6'h00, A_MSK, 6'h02, 1'b1, 1'b1}, // R9 fatal bit
    '{6'h00, 1'b1, A_RAW, 6'h3F, A_RAW, 6'h00, 1'b0, 1'b0}, // R6
    '{6'h08, 1'b1, A_MSK, 6'h08, A_MSK, 6'h08, 1'b1, 1'b0}, // R7 same-cycle collision
    '{6'h00, 1'b1, A_CLR, 6'h3F, A_CLR, 6'h00, 1'b0, 1'b0}, // R5 read via clear offset
    '{6'h20, 1'b1, A_SET, 6'h20, A_MSK, 6'h20, 1'b1, 1'b0}, // R4 R8 enable with event
    '{6'h00, 1'b1, 8'h10, 6'h3F, 8'h10, 6'h00, 1'b1, 1'b0}, // R10 unmapped
    '{6'h00, 1'b1, A_RAW, 6'h00, A_RAW, 6'h28, 1'b1, 1'b0}  // R6 zero data keeps bits
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  evt = '0;
  logic        rq_v = 1'b0, rq_w = 1'b0;
  logic [7:0]  rq_a = '0;
  logic [31:0] rq_d = '0;
  logic        rq_rdy, rs_v, irq, fat;
  logic [31:0] rs_d;
  int unsigned n_chk = 0, n_bad = 0, cyc = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  err_irq_collector i_err_irq_collector (
    .clk_i(clk), .rst_ni(rst_n), .err_evt_i(evt),
    .req_valid_i(rq_v), .req_ready_o(rq_rdy), .req_write_i(rq_w),
    .req_addr_i(rq_a), .req_wdata_i(rq_d),
    .rsp_valid_o(rs_v), .rsp_data_o(rs_d),
    .err_irq_o(irq), .err_fatal_o(fat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    evt = '0; rq_v = 1'b0; rq_w = 1'b0; rq_a = '0; rq_d = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); idle(); rq_v = 1'b1; rq_a = a;
    @(negedge clk); idle();
    chk({req, " rsp_valid"}, {31'd0, rs_v}, 32'd1);
    chk(req, rs_d, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [5:0] e);
    @(negedge clk); idle(); rq_v = 1'b1; rq_w = 1'b1; rq_a = a; rq_d = d; evt = e;
    @(negedge clk); idle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 fatal", {31'd0, fat}, 32'd0);
    rd_chk("R1 raw", A_RAW, 32'd0);
    rd_chk("R1 masked", A_MSK, 32'd0);
    rd_chk("R1 enable", A_SET, 32'd0);
    rd_chk("R1 enable alt", A_CLR, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk); idle();
      evt = VECS[i].evt; rq_v = VECS[i].wr; rq_w = VECS[i].wr;
      rq_a = VECS[i].waddr; rq_d = {26'd0, VECS[i].wdata};
      @(negedge clk); idle();
      chk($sformatf("R8 irq vec%0d", i), {31'd0, irq}, {31'd0, VECS[i].eirq});
      chk($sformatf("R9 fatal vec%0d", i), {31'd0, fat}, {31'd0, VECS[i].efat});
      rq_v = 1'b1; rq_a = VECS[i].raddr;
      @(negedge clk); idle();
      chk($sformatf("R11 rsp vec%0d", i), {31'd0, rs_v}, 32'd1);
      chk($sformatf("R3 read vec%0d", i), rs_d, {26'd0, VECS[i].erd});
    end

    // R10: upper write data bits ignored (enable stays 0x20)
    wr(A_SET, 32'hFFFF_FFC0, 6'h00);
    rd_chk("R10 upper wdata", A_SET, 32'h20);
    // R11: write gives no response; response lasts one cycle; ready high
    wr(A_SET, 32'h0, 6'h00);
    chk("R11 no wr rsp", {31'd0, rs_v}, 32'd0);
    chk("R11 ready", {31'd0, rq_rdy}, 32'd1);
    rd_chk("R11 read", A_RAW, 32'h28);
    @(negedge clk);
    chk("R11 single pulse", {31'd0, rs_v}, 32'd0);
    // R2 bit stays set with no further stimulus
    repeat (5) @(negedge clk);
    rd_chk("R2 sticky", A_RAW, 32'h28);
    // R9 both fatal sources under a full enable
    wr(A_SET, 32'h3F, 6'h12);
    chk("R9 fatal both", {31'd0, fat}, 32'd1);
    wr(A_MSK, 32'h02, 6'h00);
    chk("R9 still fatal bit4", {31'd0, fat}, 32'd1);
    wr(A_RAW, 32'h10, 6'h00);
    chk("R9 fatal gone", {31'd0, fat}, 32'd0);
    chk("R8 irq remains", {31'd0, irq}, 32'd1);
    // R1 reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd_chk("R1 raw after reset", A_RAW, 32'd0);
    rd_chk("R1 enable after reset", A_SET, 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule